// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register Block

This block holds the software-visible state of a four-channel DMA controller: a per-channel source address, destination address, transfer count and control word, plus one global operation word. It decodes register writes and reads on a simple synchronous bus. From the control words and the operation word it derives a per-channel enable, a controller-wide enable and their combination. It also shows each channel's request-source field to the trigger logic.

A transfer engine outside this block reports a finished count by pulsing a per-channel done strobe. The block then sets the channel's transfer-end flag and, if that channel's interrupt enable is set, raises a level interrupt request. The request stays up until software writes a control word that leaves either flag clear.

Top module: `dmac_chan_regs`

## Requirements
- R1: After reset every register reads 0, and `irqReq`, `chanEnabled`, `ctrlEnabled`, `chanGo` and `chanSource` are all 0.
- R2: In a control word, bit 0 is the channel enable (DE), bit 1 is transfer end (TE), bit 2 is interrupt enable (IE), and bits 11:8 are the request source. The source of channel n appears on `chanSource[4n+3:4n]`.
- R3: `chanEnabled[n]` is 1 exactly when bits 1:0 of channel n's control word are 01.
- R4: `ctrlEnabled` is 1 exactly when bits 2:0 of the operation word are 001. Higher bits do not matter, so 0x9 enables and 0x3 and 0x5 do not. `chanGo[n]` is `chanEnabled[n]` AND `ctrlEnabled`.
- R5: Channel n's registers sit at n*0x10 plus an offset: source +0x0, destination +0x4, count +0x8, control +0xC. The operation word is at 0x40. Other addresses read 0, and writes to them change nothing.
- R6: Only address bits 11:0 are decoded, so 0x1024 and 0xF024 reach the same register as 0x024.
- R7: A done pulse on channel n sets its TE, visible from the next cycle. `irqReq[n]` rises in that same cycle only if IE is set in the resulting control word.
- R8: A control write that leaves IE or TE clear drops a pending `irqReq[n]` on the next cycle. A write that keeps both set leaves it pending.
- R9: When a control write and a done pulse hit the same channel in the same cycle, TE ends up set whatever value was written. The other fields take the written value.
- R10: A software write that sets IE and TE never raises `irqReq` by itself. Only a done pulse can raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 32 | Register byte address (bits 11:0 decoded) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| xferDone | input | 4 | Per-channel count-finished pulse from the engine |
| chanEnabled | output | 4 | Per-channel enable (DE set, TE clear) |
| ctrlEnabled | output | 1 | Controller enable from the operation word |
| chanGo | output | 4 | Channel enable gated by controller enable |
| chanSource | output | 16 | Request-source field of each channel, 4 bits each |
| irqReq | output | 4 | Per-channel level interrupt request |

## Verification
The bench drives operation words whose low three bits are 001 but whose high bits are set, and words with the wrong low pattern. A decoder that tests a single bit or the whole word would then enable the controller at the wrong time. It writes through aliased high addresses and checks that unmapped writes do not land in another channel's registers, which is where faulty masking or stride arithmetic shows up. On the interrupt path it checks several cases:
- a write that clears only IE, and one that clears only TE;
- a write that keeps both flags and so must leave the request pending;
- a software write setting both flags, which must not raise the request;
- a done pulse on a channel without IE.

A write that collides with a done pulse is also checked. A design that lets software win that collision would lose the transfer-end event and its interrupt.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

  localparam int CH_IDX_MAX_W = 8;

  localparam int CTL_DE_BIT  = 0;
  localparam int CTL_TE_BIT  = 1;
  localparam int CTL_IE_BIT  = 2;
  localparam int CTL_SRC_LSB = 8;
  localparam int CTL_SRC_W   = 4;

  localparam int          OP_EN_W   = 3;
  localparam logic [2:0]  OP_EN_VAL = 3'b001;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SRC,
    SEL_DST,
    SEL_CNT,
    SEL_CTL,
    SEL_OP
  } rdSel_e;

  typedef struct packed {
    logic                    wrSrc;
    logic                    wrDst;
    logic                    wrCnt;
    logic                    wrCtl;
    logic                    wrOp;
    rdSel_e                  rdSel;
    logic [CH_IDX_MAX_W-1:0] chan;
  } regStrobe_t;

endpackage

// File: rtl/dmac_reg_decode.sv
module dmac_reg_decode
  import dmac_regs_pkg::*;
#(
  parameter int BUS_ADDR_W  = 32,
  parameter int MAP_W       = 12,
  parameter int NUM_CH      = 4,
  parameter int STRIDE_LOG2 = 4,
  parameter int CHAN_BASE   = 'h000,
  parameter int OP_ADDR     = 'h040,
  parameter int OFF_SRC     = 'h0,
  parameter int OFF_DST     = 'h4,
  parameter int OFF_CNT     = 'h8,
  parameter int OFF_CTL     = 'hC
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [BUS_ADDR_W-1:0] addr,
  output regStrobe_t            strobe
);

  localparam logic [MAP_W-1:0]       BASE_L = MAP_W'(CHAN_BASE);
  localparam logic [MAP_W-1:0]       WIN_L  = MAP_W'(NUM_CH << STRIDE_LOG2);
  localparam logic [MAP_W-1:0]       OP_L   = MAP_W'(OP_ADDR);
  localparam logic [STRIDE_LOG2-1:0] SRC_L  = STRIDE_LOG2'(OFF_SRC);
  localparam logic [STRIDE_LOG2-1:0] DST_L  = STRIDE_LOG2'(OFF_DST);
  localparam logic [STRIDE_LOG2-1:0] CNT_L  = STRIDE_LOG2'(OFF_CNT);
  localparam logic [STRIDE_LOG2-1:0] CTL_L  = STRIDE_LOG2'(OFF_CTL);

  logic [MAP_W-1:0]       addrLocal;
  logic [MAP_W-1:0]       relAddr;
  logic [STRIDE_LOG2-1:0] offset;
  logic                   inWin;
  rdSel_e                 sel;

  logic unusedAddrHi;
  assign unusedAddrHi = ^addr[BUS_ADDR_W-1:MAP_W];

  always_comb begin
    addrLocal = addr[MAP_W-1:0];
    relAddr   = addrLocal - BASE_L;
    inWin     = relAddr < WIN_L;
    offset    = relAddr[STRIDE_LOG2-1:0];
    sel       = SEL_NONE;
    if (inWin) begin
      case (offset)
        SRC_L:   sel = SEL_SRC;
        DST_L:   sel = SEL_DST;
        CNT_L:   sel = SEL_CNT;
        CTL_L:   sel = SEL_CTL;
        default: sel = SEL_NONE;
      endcase
    end else if (addrLocal == OP_L) begin
      sel = SEL_OP;
    end
  end

  always_comb begin
    strobe.rdSel = sel;
    strobe.chan  = CH_IDX_MAX_W'(relAddr >> STRIDE_LOG2);
    strobe.wrSrc = wrEn && (sel == SEL_SRC);
    strobe.wrDst = wrEn && (sel == SEL_DST);
    strobe.wrCnt = wrEn && (sel == SEL_CNT);
    strobe.wrCtl = wrEn && (sel == SEL_CTL);
    strobe.wrOp  = wrEn && (sel == SEL_OP);
  end

  // R5: any per-channel write names a channel that exists
  assert_wr_chan_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrSrc || strobe.wrDst || strobe.wrCnt || strobe.wrCtl)
      |-> (int'(strobe.chan) < NUM_CH));

  // R5: at most one register is written per cycle
  assert_wr_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrSrc, strobe.wrDst, strobe.wrCnt, strobe.wrCtl, strobe.wrOp}));

endmodule

// File: rtl/dmac_reg_file.sv
module dmac_reg_file
  import dmac_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStrobe_t                    strobe,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NUM_CH-1:0]             xferDone,
  output logic [DATA_W-1:0]             rdData,
  output logic [NUM_CH-1:0]             chanEnabled,
  output logic                          ctrlEnabled,
  output logic [NUM_CH*CTL_SRC_W-1:0]   chanSource,
  output logic [NUM_CH-1:0]             irqReq
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0][DATA_W-1:0] srcReg;
  logic [NUM_CH-1:0][DATA_W-1:0] dstReg;
  logic [NUM_CH-1:0][DATA_W-1:0] cntReg;
  logic [NUM_CH-1:0][DATA_W-1:0] ctlReg;
  logic [NUM_CH-1:0][DATA_W-1:0] ctlNext;
  logic [DATA_W-1:0]             opReg;
  logic [NUM_CH-1:0]             irqNext;

  logic [NUM_CH-1:0] chanHit;
  logic [NUM_CH-1:0] ctlHit;
  logic [CH_W-1:0]   chIdx;

  assign chIdx = CH_W'(strobe.chan);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    assign chanHit[g] = (strobe.chan == CH_IDX_MAX_W'(g));
    assign ctlHit[g]  = strobe.wrCtl && chanHit[g];
    assign chanEnabled[g] = ctlReg[g][CTL_TE_BIT:CTL_DE_BIT] == 2'b01;
    assign chanSource[g*CTL_SRC_W +: CTL_SRC_W] =
      ctlReg[g][CTL_SRC_LSB +: CTL_SRC_W];

    // R7: a pending request always has both flags behind it
    assert_irq_has_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
      irqReq[g] |-> (ctlReg[g][CTL_IE_BIT] && ctlReg[g][CTL_TE_BIT]));

    // R9: a done pulse always leaves transfer end set
    assert_done_sets_te_R9: assert property (@(posedge clk) disable iff (!rstN)
      xferDone[g] |=> ctlReg[g][CTL_TE_BIT]);

    // R10: the request only rises after a done pulse
    assert_irq_rise_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqReq[g]) |-> $past(xferDone[g]));

    // R8: writing IE clear withdraws the request
    assert_ie_clear_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
      (ctlHit[g] && !wrData[CTL_IE_BIT]) |=> !irqReq[g]);

    // R8: writing TE clear withdraws the request unless the engine sets it
    assert_te_clear_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
      (ctlHit[g] && !wrData[CTL_TE_BIT] && !xferDone[g]) |=> !irqReq[g]);
  end

  assign ctrlEnabled = opReg[OP_EN_W-1:0] == OP_EN_VAL;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      ctlNext[i] = ctlHit[i] ? wrData : ctlReg[i];
      if (xferDone[i]) ctlNext[i][CTL_TE_BIT] = 1'b1;
      irqNext[i] = irqReq[i];
      if (xferDone[i] && ctlNext[i][CTL_IE_BIT])
        irqNext[i] = 1'b1;
      else if (ctlHit[i] && !(ctlNext[i][CTL_IE_BIT] && ctlNext[i][CTL_TE_BIT]))
        irqNext[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg <= '0;
      dstReg <= '0;
      cntReg <= '0;
      ctlReg <= '0;
      opReg  <= '0;
      irqReq <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (strobe.wrSrc && chanHit[i]) srcReg[i] <= wrData;
        if (strobe.wrDst && chanHit[i]) dstReg[i] <= wrData;
        if (strobe.wrCnt && chanHit[i]) cntReg[i] <= wrData;
      end
      ctlReg <= ctlNext;
      irqReq <= irqNext;
      if (strobe.wrOp) opReg <= wrData;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_SRC: rdData = srcReg[chIdx];
      SEL_DST: rdData = dstReg[chIdx];
      SEL_CNT: rdData = cntReg[chIdx];
      SEL_CTL: rdData = ctlReg[chIdx];
      SEL_OP:  rdData = opReg;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_regs_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int DATA_W     = 32,
  parameter int BUS_ADDR_W = 32,
  parameter int MAP_W      = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic [BUS_ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]           regWrData,
  output logic [DATA_W-1:0]           regRdData,
  input  logic [NUM_CH-1:0]           xferDone,
  output logic [NUM_CH-1:0]           chanEnabled,
  output logic                        ctrlEnabled,
  output logic [NUM_CH-1:0]           chanGo,
  output logic [NUM_CH*CTL_SRC_W-1:0] chanSource,
  output logic [NUM_CH-1:0]           irqReq
);

  regStrobe_t strobe;

  dmac_reg_decode #(
    .BUS_ADDR_W (BUS_ADDR_W),
    .MAP_W      (MAP_W),
    .NUM_CH     (NUM_CH)
  ) u_decode (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .addr   (regAddr),
    .strobe (strobe)
  );

  dmac_reg_file #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (regWrData),
    .xferDone    (xferDone),
    .rdData      (regRdData),
    .chanEnabled (chanEnabled),
    .ctrlEnabled (ctrlEnabled),
    .chanSource  (chanSource),
    .irqReq      (irqReq)
  );

  assign chanGo = chanEnabled & {NUM_CH{ctrlEnabled}};

endmodule

// File: tb/dmac_chan_regs_bench.sv
`timescale 1ns/1ps
module dmac_chan_regs_bench;

  localparam int K_RD   = 0;
  localparam int K_IRQ  = 1;
  localparam int K_CHEN = 2;
  localparam int K_CEN  = 3;
  localparam int K_GO   = 4;
  localparam int K_SRC  = 5;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [31:0] regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [3:0]  xferDone;
  logic [3:0]  chanEnabled;
  logic        ctrlEnabled;
  logic [3:0]  chanGo;
  logic [15:0] chanSource;
  logic [3:0]  irqReq;

  always #2.5 clk = ~clk;

  dmac_chan_regs u_dmac_chan_regs (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .xferDone    (xferDone),
    .chanEnabled (chanEnabled),
    .ctrlEnabled (ctrlEnabled),
    .chanGo      (chanGo),
    .chanSource  (chanSource),
    .irqReq      (irqReq)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] observe(int kind);
    case (kind)
      K_RD:    return regRdData;
      K_IRQ:   return {28'd0, irqReq};
      K_CHEN:  return {28'd0, chanEnabled};
      K_CEN:   return {31'd0, ctrlEnabled};
      K_GO:    return {28'd0, chanGo};
      default: return {16'd0, chanSource};
    endcase
  endfunction

  // monitor: pops expectations and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [31:0] act;
        it  = expQ.pop_front();
        act = observe(it.kind);
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic pushExp(int kind, logic [31:0] exp, string req);
    expItem_t it;
    it.kind = kind;
    it.exp  = exp;
    it.req  = req;
    expQ.push_back(it);
  endtask

  task automatic regWr(logic [31:0] a, logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic pulseDone(logic [3:0] m);
    @(posedge clk); #1;
    xferDone = m;
    @(posedge clk); #1;
    xferDone = '0;
  endtask

  task automatic wrWithDone(logic [31:0] a, logic [31:0] d, logic [3:0] m);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d; xferDone = m;
    @(posedge clk); #1;
    regWrEn = 1'b0; xferDone = '0;
  endtask

  task automatic checkRd(logic [31:0] a, logic [31:0] exp, string req);
    regAddr = a;
    pushExp(K_RD, exp, req);
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0; xferDone = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    pushExp(K_IRQ, 0, "R1");
    pushExp(K_CHEN, 0, "R1");
    pushExp(K_CEN, 0, "R1");
    pushExp(K_GO, 0, "R1");
    pushExp(K_SRC, 0, "R1");
    checkRd(32'h0C, 0, "R1");
    checkRd(32'h40, 0, "R1");
    checkRd(32'h38, 0, "R1");

    // R4 controller enable pattern
    regWr(32'h40, 32'h1); pushExp(K_CEN, 1, "R4 op=1");
    regWr(32'h40, 32'h9); pushExp(K_CEN, 1, "R4 op=9");
    checkRd(32'h40, 32'h9, "R4 readback");
    regWr(32'h40, 32'h3); pushExp(K_CEN, 0, "R4 op=3");
    regWr(32'h40, 32'h5); pushExp(K_CEN, 0, "R4 op=5");
    regWr(32'h40, 32'h1);

    // R5 stride and offsets, unmapped holes
    regWr(32'h20, 32'hA5A5_0001);
    regWr(32'h34, 32'h1357_9BDF);
    regWr(32'h18, 32'h0000_0040);
    checkRd(32'h20, 32'hA5A5_0001, "R5 ch2 src");
    checkRd(32'h34, 32'h1357_9BDF, "R5 ch3 dst");
    checkRd(32'h18, 32'h0000_0040, "R5 ch1 cnt");
    checkRd(32'h24, 0, "R5 ch2 dst untouched");
    regWr(32'h50, 32'hFFFF_FFFF);
    checkRd(32'h50, 0, "R5 unmapped read");
    checkRd(32'h0C, 0, "R5 unmapped write ignored");
    checkRd(32'h00, 0, "R5 unmapped write ignored");
    checkRd(32'h40, 32'h1, "R5 unmapped write ignored");

    // R6 address masking
    regWr(32'h0000_1024, 32'h0000_1234);
    checkRd(32'h024, 32'h1234, "R6 alias write");
    checkRd(32'hF024, 32'h1234, "R6 alias read");

    // R2 / R3 field positions and channel enable
    regWr(32'h0C, 32'h501);
    pushExp(K_CHEN, 4'b0001, "R3 DE only");
    pushExp(K_GO, 4'b0001, "R4 go");
    pushExp(K_SRC, 16'h0005, "R2 source ch0");
    regWr(32'h1C, 32'h3);
    pushExp(K_CHEN, 4'b0001, "R3 DE+TE not enabled");
    checkRd(32'h1C, 32'h3, "R2 ctl readback");
    regWr(32'h2C, 32'hB02);
    pushExp(K_SRC, 16'h0B05, "R2 source ch2");
    pushExp(K_CHEN, 4'b0001, "R3 TE only");
    regWr(32'h40, 32'h0);
    pushExp(K_GO, 0, "R4 go gated");
    pushExp(K_CHEN, 4'b0001, "R4 chan enable independent");
    regWr(32'h40, 32'h1);

    // R7 done sets TE, raises irq only with IE
    regWr(32'h0C, 32'h505);
    pulseDone(4'b0001);
    pushExp(K_IRQ, 4'b0001, "R7 done with IE");
    pushExp(K_CHEN, 4'b0000, "R7 TE disables");
    checkRd(32'h0C, 32'h507, "R7 TE set");
    regWr(32'h2C, 32'hB00);
    pulseDone(4'b0100);
    pushExp(K_IRQ, 4'b0001, "R7 done without IE");
    checkRd(32'h2C, 32'hB02, "R7 TE set without IE");

    // R8 clearing IE withdraws
    regWr(32'h0C, 32'h503);
    pushExp(K_IRQ, 0, "R8 IE cleared");
    checkRd(32'h0C, 32'h503, "R8 ctl value");

    // R10 software setting both flags raises nothing
    regWr(32'h0C, 32'h507);
    pushExp(K_IRQ, 0, "R10 sw IE+TE");

    pulseDone(4'b0001);
    pushExp(K_IRQ, 4'b0001, "R7 done again");

    // R8 keep both flags, then clear TE
    regWr(32'h0C, 32'h107);
    pushExp(K_IRQ, 4'b0001, "R8 flags kept");
    pushExp(K_SRC, 16'h0B01, "R2 source rewrite");
    regWr(32'h0C, 32'h105);
    pushExp(K_IRQ, 0, "R8 TE cleared");
    pushExp(K_CHEN, 4'b0001, "R3 re-enabled");

    // R9 collision: engine TE wins
    regWr(32'h3C, 32'h4);
    wrWithDone(32'h3C, 32'h5, 4'b1000);
    pushExp(K_IRQ, 4'b1000, "R9 collision irq");
    pushExp(K_CHEN, 4'b0001, "R9 collision TE");
    checkRd(32'h3C, 32'h7, "R9 collision value");
    wrWithDone(32'h3C, 32'h1, 4'b1000);
    pushExp(K_IRQ, 0, "R9 collision IE cleared");
    checkRd(32'h3C, 32'h3, "R9 TE kept");

    // R10 other channel
    regWr(32'h2C, 32'h6);
    pushExp(K_IRQ, 0, "R10 sw IE+TE ch2");
    checkRd(32'h2C, 32'h6, "R10 ctl value");
    pushExp(K_GO, 4'b0001, "R4 go final");

    repeat (2) @(negedge clk);
    #1;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule